// File: doc/BRIEF.md
# Sequential Booth Multiplier (signed 8 x 8)

This block multiplies two signed two's-complement operands, a multiplicand and a multiplier, and returns their full-width signed product. It retires one radix-2 Booth recode step per clock. Each step looks at the lowest bit of the shifting multiplier register and the extension bit to its right. It then either holds, adds the multiplicand, or subtracts it from the accumulator. Finally it shifts accumulator, multiplier and extension bit right together with sign replication.

A caller presents both operands and raises `start_i` for one clock period, changing it on a falling clock edge. The block captures the request on the next rising edge and raises `busy_o`. When `busy_o` drops, `prod_o` holds the product and keeps it until the next accepted start. Requests made while the block is busy are dropped.

Top module: `booth_mult`

## Requirements
- R1: After reset, `prod_o` is 0 and `busy_o` is 0.
- R2: A rising clock edge that sees `start_i` high while `busy_o` is low captures both operands. It clears the accumulator and the extension bit, and `busy_o` is high from that edge on.
- R3: `busy_o` stays high for exactly WIDTH (8) clock cycles after the capturing edge, then falls.
- R4: When `busy_o` falls, `prod_o` equals the signed product of the captured operands as a 16-bit two's-complement value, with the accumulator in bits 15:8 and the multiplier register in bits 7:0.
- R5: The corner case -128 x -128 yields +16384 (0x4000). -128 x 127 yields -16256.
- R6: While `busy_o` is low and no start is captured, `prod_o` does not change, even when the operand inputs change.
- R7: A start request seen while `busy_o` is high has no effect. The running operation finishes on its original schedule with the product of the operands captured first.
- R8: A recode step that neither adds nor subtracts shifts the accumulator arithmetically, so its sign bit is kept and copied down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled on rising edges |
| mcand_i | input | 8 | Signed multiplicand |
| mplier_i | input | 8 | Signed multiplier |
| prod_o | output | 16 | Signed product, valid while busy is low |
| busy_o | output | 1 | High while recode steps are running |

## Verification
Assertions check on every cycle that a capture starts a run with the counter at zero and a cleared accumulator. They also check that the run ends after exactly the last step and that the held multiplicand cannot change mid-run. Further cycle checks cover the idle product staying stable, hold steps keeping the accumulator sign, and mid-run requests leaving the step count untouched. Arithmetic correctness cannot be seen cycle by cycle. The bench shows it by sweeping every multiplicand against a set of multiplier values and random pairs, comparing against products computed in the bench. Directed scenarios cover the extreme corners and the dropping of a mid-run request.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    RC_HOLD = 2'd0,
    RC_ADD  = 2'd1,
    RC_SUB  = 2'd2
  } recode_e;

  // Radix-2 recode of the bit pair {current LSB, extension bit}
  function automatic recode_e recode(input logic lsb, input logic ext);
    case ({lsb, ext})
      2'b01:   return RC_ADD;
      2'b10:   return RC_SUB;
      default: return RC_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic step
);

  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  assign load   = start & ~busy_q;
  assign step   = busy_q;
  assign busy   = busy_q;
  assign cnt_en = load | step;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assert_load_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && cnt_q == '0));

  assert_run_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> !busy_q);

  assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> busy_q);

  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] prod
);

  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    acc_q, acc_d, acc_sum, m_ext;
  logic [WIDTH-1:0] q_q, q_d, m_q;
  logic             ext_q, ext_d;
  logic             reg_en;
  recode_e          op;

  assign m_ext  = {m_q[WIDTH-1], m_q};
  assign op     = recode(q_q[0], ext_q);
  assign reg_en = load | step;

  always_comb begin
    case (op)
      RC_ADD:  acc_sum = acc_q + m_ext;
      RC_SUB:  acc_sum = acc_q - m_ext;
      default: acc_sum = acc_q;
    endcase
  end

  always_comb begin
    if (load) begin
      acc_d = '0;
      q_d   = mplier;
      ext_d = 1'b0;
    end else begin
      acc_d = {acc_sum[AW-1], acc_sum[AW-1:1]};
      q_d   = {acc_sum[0], q_q[WIDTH-1:1]};
      ext_d = q_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      q_q   <= '0;
      ext_q <= 1'b0;
      m_q   <= '0;
    end else begin
      if (reg_en) begin
        acc_q <= acc_d;
        q_q   <= q_d;
        ext_q <= ext_d;
      end
      if (load) m_q <= mcand;
    end
  end

  assign prod = {acc_q[WIDTH-1:0], q_q};

  assert_clear_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == '0 && !ext_q && q_q == $past(mplier)));

  assert_mcand_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(m_q));

  assert_sign_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == RC_HOLD) |=>
      (acc_q[AW-1] == $past(acc_q[AW-1]) && acc_q[AW-2] == acc_q[AW-1]));

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o,
  output logic               busy_o
);

  logic load, step;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .busy  (busy_o),
    .load  (load),
    .step  (step)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .mcand  (mcand_i),
    .mplier (mplier_i),
    .prod   (prod_o)
  );

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(prod_o));

endmodule

// File: tb/booth_mult_bench.sv
module booth_mult_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  mcand_i = '0;
  logic [7:0]  mplier_i = '0;
  logic [15:0] prod_o;
  logic        busy_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  booth_mult u_booth_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .prod_o   (prod_o),
    .busy_o   (busy_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[15:0];
  endfunction

  // Starts at a falling edge; returns at the falling edge after busy should fall
  task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                        input bit full, input int poke_at);
    mcand_i  = a;
    mplier_i = b;
    start_i  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    if (full) check("R2 busy after capture", {15'd0, busy_o}, 16'd1);
    for (int i = 1; i < 8; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == poke_at) begin
        mcand_i  = 8'h55;
        mplier_i = 8'h33;
        start_i  = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    if (full) check("R3 busy through last step", {15'd0, busy_o}, 16'd1);
    start_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R3 busy low after 8 steps", {15'd0, busy_o}, 16'd0);
    check("R4 product", prod_o, ref_mul(a, b));
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] held;
    logic [7:0] corners [16];
    corners = '{8'h00, 8'h01, 8'hFF, 8'h7F, 8'h80, 8'h02, 8'hFE, 8'h55,
                8'hAA, 8'h40, 8'hC0, 8'h0F, 8'hF0, 8'h81, 8'h7E, 8'h33};
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset product", prod_o, 16'h0000);
    check("R1 reset busy", {15'd0, busy_o}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 corners
    run_op(8'h80, 8'h80, 1'b1, 0);
    check("R5 -128*-128", prod_o, 16'h4000);
    run_op(8'h80, 8'h7F, 1'b1, 0);
    check("R5 -128*127", prod_o, 16'hC080);
    run_op(8'h7F, 8'h80, 1'b1, 0);
    check("R5 127*-128", prod_o, 16'hC080);

    // R6: idle product holds while inputs wander
    held = 8'h00;
    for (int k = 0; k < 6; k++) begin
      mcand_i  = 8'(k * 37);
      mplier_i = 8'(k * 91);
      @(posedge clk);
      @(negedge clk);
      check("R6 idle product stable", prod_o, 16'hC080);
    end

    // R7: start request in the middle of a run is dropped
    run_op(8'hF9, 8'h0B, 1'b1, 3);
    check("R7 mid-run start ignored", prod_o, ref_mul(8'hF9, 8'h0B));
    run_op(8'h80, 8'hFF, 1'b1, 7);
    check("R7 late start ignored", prod_o, 16'h0080);

    // R4 / R8: every multiplicand against a set of multipliers
    for (int j = 0; j < 16; j++) begin
      for (int a = 0; a < 256; a++) begin
        run_op(8'(a), corners[j], (a % 64) == 0, 0);
      end
    end

    // R4: pseudo-random pairs
    for (int r = 0; r < 1500; r++) begin
      held = 8'($urandom_range(0, 255));
      run_op(held, 8'($urandom_range(0, 255)), 1'b0, 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule